// File: doc/BRIEF.md
# Single-Error-Correcting Byte Memory with Error Flag

This block is a word-addressed storage array holding 8-bit data words, each kept alongside four check bits as a 12-bit Hamming codeword. A host selects the block with active-low chip-enable, output-enable and write-enable strobes. A separate active-low sleep input blocks every access while it is low. Writes are committed on the rising clock edge: the check bits are computed from the incoming byte, and the whole codeword is stored. Reads are combinational from the address. If exactly one stored bit has flipped, the data returned is repaired and an error flag is raised.

The flag has three states, shown as a value plus a drive-enable. It is driven low on a clean read and driven high when a read repaired a bit. It is not driven when the block is deselected, when its outputs are disabled, during a write, or in sleep. A repaired value is never written back, so the fault stays in the array until the host writes that word again. A fault-injection port XORs a 12-bit one-hot mask into one stored codeword without recomputing its check bits, so tests can create single-bit faults on purpose. The depth is set by the address-width parameter: 19 address bits gives the full 512K-word size, and the default is smaller.

Top module: `ecc_byte_sram`

## Requirements
- R1: A write stores a byte so that a later read at the same address returns it with the flag driven low.
- R2: If one data bit of a stored codeword is flipped, a read returns the original byte with the flag driven high. In the codeword, bit positions 1, 2, 4 and 8 hold check bits, and data bits 0..7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. Mask bit k flips position k+1.
- R3: If a check bit (position 1, 2, 4 or 8) is flipped, a read returns the byte unchanged and still drives the flag high.
- R4: A repaired read does not write back: reading the same word again still raises the flag, until a new write to that word stores a clean codeword.
- R5: With sleep high and chip-enable high (standby), neither the data bus nor the flag is driven, and no write happens.
- R6: With sleep high, chip-enable low, output-enable low and write-enable high, the block reads: it drives the data bus and the flag.
- R7: With sleep high, chip-enable low and write-enable low, the block writes whatever output-enable is, and drives neither the data bus nor the flag.
- R8: With sleep high, chip-enable low and both output-enable and write-enable high, nothing is driven and the array is unchanged.
- R9: With sleep low, all other strobes are ignored: nothing is driven and no write happens.
- R10: Read data and the flag follow an address change in the same cycle, with no clock edge in between.
- R11: Fault injection changes the stored codeword without recomputing its check bits, so an injected single flip is always detected on the next read.
- R12: While reset is low, writes and fault injections are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and injections take effect on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes and injections |
| sleep_n | input | 1 | Active-low sleep; low disables all access |
| cs_n | input | 1 | Active-low chip select |
| rd_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 8 | Byte to store |
| rdata | output | 8 | Repaired read byte; zero when not driven |
| rdata_oe | output | 1 | High when the data bus is driven |
| err_flag | output | 1 | High when a read repaired one bit |
| err_oe | output | 1 | High when the flag is driven |
| inj_en | input | 1 | Apply the injection mask on this edge |
| inj_addr | input | ADDR_W | Word that receives the injection |
| inj_mask | input | 12 | Bits of the stored codeword to flip |

## Verification
The read outputs and both drive-enables are combinational, so they are due zero cycles after the strobes or the address change. The bench moves inputs on the falling edge and samples one nanosecond later, with no rising edge in between. Writes and injections land on the next rising edge, so they show on the first read driven at the falling edge after that edge. Each task drives one falling-to-falling window for a write or an injection, and only then reads back.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;
  localparam int CW_W   = DATA_W + CHK_W;

  typedef enum logic [2:0] {
    MODE_SLEEP, MODE_STANDBY, MODE_READ, MODE_WRITE, MODE_QUIET
  } mode_e;

  function automatic bit is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Codeword position (1-based) holding data bit i.
  function automatic int data_pos(int i);
    int n;
    n = 0;
    data_pos = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_pow2(p)) begin
        if (n == i) data_pos = p;
        n++;
      end
    end
  endfunction

  function automatic logic [CW_W-1:0] encode(logic [DATA_W-1:0] d);
    logic [CW_W-1:0] cw;
    cw = '0;
    for (int i = 0; i < DATA_W; i++) cw[data_pos(i)-1] = d[i];
    for (int k = 0; k < CHK_W; k++) begin
      for (int i = 0; i < DATA_W; i++) begin
        if (((data_pos(i) >> k) & 1) == 1) cw[(1 << k) - 1] = cw[(1 << k) - 1] ^ d[i];
      end
    end
    return cw;
  endfunction

  function automatic logic [CHK_W-1:0] syndrome(logic [CW_W-1:0] cw);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int p = 1; p <= CW_W; p++) begin
      if (cw[p-1]) s = s ^ CHK_W'(p);
    end
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] extract(logic [CW_W-1:0] cw);
    logic [DATA_W-1:0] d;
    for (int i = 0; i < DATA_W; i++) d[i] = cw[data_pos(i)-1];
    return d;
  endfunction
endpackage

// File: rtl/ecc_sram_mode_dec.sv
module ecc_sram_mode_dec
  import ecc_sram_pkg::*;
(
  input  logic  sleep_n,
  input  logic  cs_n,
  input  logic  rd_en_n,
  input  logic  wr_en_n,
  output mode_e mode,
  output logic  rd_act,
  output logic  wr_act
);
  always_comb begin
    if (!sleep_n)      mode = MODE_SLEEP;
    else if (cs_n)     mode = MODE_STANDBY;
    else if (!wr_en_n) mode = MODE_WRITE;
    else if (!rd_en_n) mode = MODE_READ;
    else               mode = MODE_QUIET;
  end

  assign rd_act = (mode == MODE_READ);
  assign wr_act = (mode == MODE_WRITE);
endmodule

// File: rtl/ecc_sram_array.sv
module ecc_sram_array
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW_W-1:0]   wr_cw,
  input  logic              inj_fire,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [CW_W-1:0]   inj_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CW_W-1:0]   rd_cw
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CW_W-1:0] mem [DEPTH];

  logic same_word;
  assign same_word = wr_fire && inj_fire && (wr_addr == inj_addr);

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_addr] <= same_word ? (wr_cw ^ inj_mask) : wr_cw;
    if (inj_fire && !same_word) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
  end

  assign rd_cw = mem[rd_addr];
endmodule

// File: rtl/ecc_sram_corrector.sv
module ecc_sram_corrector
  import ecc_sram_pkg::*;
(
  input  logic [CW_W-1:0]   cw,
  output logic [DATA_W-1:0] data,
  output logic              fixed_one
);
  logic [CHK_W-1:0] syn;
  logic [CW_W-1:0]  repaired;

  always_comb begin
    syn      = syndrome(cw);
    repaired = cw;
    if (syn != '0 && int'(syn) <= CW_W) repaired[syn - 1'b1] = ~cw[syn - 1'b1];
  end

  assign data      = extract(repaired);
  assign fixed_one = (syn != '0);
endmodule

// File: rtl/ecc_byte_sram.sv
module ecc_byte_sram
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_n,
  input  logic              cs_n,
  input  logic              rd_en_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rdata_oe,
  output logic              err_flag,
  output logic              err_oe,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [11:0]       inj_mask
);
  mode_e             mode;
  logic              rd_act;
  logic              wr_act;
  logic              wr_fire;
  logic              inj_fire;
  logic [CW_W-1:0]   rd_cw;
  logic [DATA_W-1:0] fix_data;
  logic              fix_err;

  ecc_sram_mode_dec u_dec (
    .sleep_n(sleep_n), .cs_n(cs_n), .rd_en_n(rd_en_n), .wr_en_n(wr_en_n),
    .mode(mode), .rd_act(rd_act), .wr_act(wr_act)
  );

  assign wr_fire  = wr_act && rst_n;
  assign inj_fire = inj_en && rst_n;

  ecc_sram_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk),
    .wr_fire(wr_fire), .wr_addr(addr), .wr_cw(encode(wdata)),
    .inj_fire(inj_fire), .inj_addr(inj_addr), .inj_mask(inj_mask),
    .rd_addr(addr), .rd_cw(rd_cw)
  );

  ecc_sram_corrector u_fix (
    .cw(rd_cw), .data(fix_data), .fixed_one(fix_err)
  );

  assign rdata_oe = rd_act;
  assign err_oe   = rd_act;
  assign rdata    = rd_act ? fix_data : '0;
  assign err_flag = rd_act && fix_err;
endmodule

// File: rtl/ecc_byte_sram_chk.sv
module ecc_byte_sram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_n,
  input logic              cs_n,
  input logic              rd_en_n,
  input logic              wr_en_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              rdata_oe,
  input logic              err_flag,
  input logic              err_oe,
  input logic              wr_fire,
  input logic              inj_fire
);
  p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> (!rdata_oe && !err_oe && !wr_fire));

  p_standby_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && cs_n) |-> (!rdata_oe && !err_oe && !wr_fire));

  p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && !cs_n && !wr_en_n) |-> (wr_fire && !rdata_oe && !err_oe));

  p_read_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && !cs_n && !rd_en_n && wr_en_n) |-> (rdata_oe && err_oe));

  p_outputs_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && !cs_n && rd_en_n && wr_en_n) |-> (!rdata_oe && !err_oe && !wr_fire));

  p_flag_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> err_oe);

  p_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_fire) && !$past(inj_fire) && $stable(addr) && rdata_oe)
      |-> (rdata == $past(wdata) && !err_flag));
endmodule

bind ecc_byte_sram ecc_byte_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .cs_n(cs_n), .rd_en_n(rd_en_n),
  .wr_en_n(wr_en_n), .addr(addr), .wdata(wdata), .rdata(rdata),
  .rdata_oe(rdata_oe), .err_flag(err_flag), .err_oe(err_oe),
  .wr_fire(wr_fire), .inj_fire(inj_fire)
);

// File: tb/ecc_byte_sram_bench.sv
module ecc_byte_sram_bench;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_n = 1'b0, cs_n = 1'b1, rd_en_n = 1'b1, wr_en_n = 1'b1;
  logic [AW-1:0] addr = '0, inj_addr = '0;
  logic [7:0]    wdata = '0;
  logic          inj_en = 1'b0;
  logic [11:0]   inj_mask = '0;
  logic [7:0]    rdata;
  logic          rdata_oe, err_flag, err_oe;

  int checks = 0;
  int errors = 0;

  // Data bit i lives at this 1-based codeword position.
  int dpos [8] = '{3, 5, 6, 7, 9, 10, 11, 12};

  always #4 clk = ~clk;

  ecc_byte_sram #(.ADDR_W(AW)) u_ecc_byte_sram (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .cs_n(cs_n), .rd_en_n(rd_en_n),
    .wr_en_n(wr_en_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .err_flag(err_flag), .err_oe(err_oe),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    sleep_n = 1'b1; cs_n = 1'b1; rd_en_n = 1'b1; wr_en_n = 1'b1;
  endtask

  task automatic do_write(input int a, input int d, input bit oe_low);
    @(negedge clk);
    sleep_n = 1'b1; cs_n = 1'b0; wr_en_n = 1'b0; rd_en_n = !oe_low;
    addr = AW'(a); wdata = 8'(d);
    #1;
    chk(!rdata_oe && !err_oe, "R7 no drive in write", {rdata_oe, err_oe}, 0);
    @(negedge clk);
    idle();
  endtask

  task automatic do_read(input int a, input int exp_d, input bit exp_f, input string req);
    @(negedge clk);
    sleep_n = 1'b1; cs_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b0; addr = AW'(a);
    #1;
    chk(rdata_oe && err_oe, {req, " drive"}, {rdata_oe, err_oe}, 3);
    chk(rdata == 8'(exp_d), {req, " data"}, rdata, exp_d);
    chk(err_flag == exp_f, {req, " flag"}, err_flag, exp_f);
  endtask

  task automatic inject(input int a, input int pos);
    @(negedge clk);
    idle();
    inj_en = 1'b1; inj_addr = AW'(a); inj_mask = 12'(1) << (pos - 1);
    @(negedge clk);
    inj_en = 1'b0; inj_mask = '0;
  endtask

  task automatic t_reset_sleep();
    #1;
    chk(!rdata_oe && !err_oe && !err_flag, "R9 sleep in reset",
        {rdata_oe, err_oe, err_flag}, 0);
  endtask

  task automatic t_basic();
    do_write(5, 8'hA5, 1'b0);
    do_write(6, 8'h3C, 1'b0);
    do_write(7, 8'h00, 1'b0);
    do_write(8, 8'hFF, 1'b0);
    do_read(5, 8'hA5, 1'b0, "R1 a5");
    do_read(6, 8'h3C, 1'b0, "R1 3c");
    do_read(7, 8'h00, 1'b0, "R1 00");
    do_read(8, 8'hFF, 1'b0, "R1 ff");
  endtask

  task automatic t_write_oe_low();
    do_write(9, 8'h96, 1'b1);
    do_read(9, 8'h96, 1'b0, "R7 write with oe low");
  endtask

  task automatic t_outputs_off();
    @(negedge clk);
    sleep_n = 1'b1; cs_n = 1'b0; rd_en_n = 1'b1; wr_en_n = 1'b1;
    addr = AW'(5); wdata = 8'h12;
    #1;
    chk(!rdata_oe && !err_oe, "R8 no drive", {rdata_oe, err_oe}, 0);
    do_read(5, 8'hA5, 1'b0, "R8 array unchanged");
  endtask

  task automatic t_standby();
    @(negedge clk);
    sleep_n = 1'b1; cs_n = 1'b1; rd_en_n = 1'b0; wr_en_n = 1'b0;
    addr = AW'(6); wdata = 8'h55;
    #1;
    chk(!rdata_oe && !err_oe, "R5 standby no drive", {rdata_oe, err_oe}, 0);
    chk(rdata == 8'h00, "R5 standby data", rdata, 0);
    @(negedge clk);
    idle();
    do_read(6, 8'h3C, 1'b0, "R5 no write in standby");
  endtask

  task automatic t_sleep();
    @(negedge clk);
    sleep_n = 1'b0; cs_n = 1'b0; rd_en_n = 1'b1; wr_en_n = 1'b0;
    addr = AW'(7); wdata = 8'h11;
    #1;
    chk(!rdata_oe && !err_oe, "R9 sleep no drive", {rdata_oe, err_oe}, 0);
    @(negedge clk);
    rd_en_n = 1'b0; wr_en_n = 1'b1;
    #1;
    chk(!rdata_oe && !err_oe, "R9 sleep read blocked", {rdata_oe, err_oe}, 0);
    @(negedge clk);
    idle();
    do_read(7, 8'h00, 1'b0, "R9 no write in sleep");
  endtask

  task automatic t_data_flips();
    for (int i = 0; i < 8; i++) begin
      do_write(20 + i, 8'h5A ^ (8'(1) << i), 1'b0);
      inject(20 + i, dpos[i]);
      do_read(20 + i, 8'h5A ^ (8'(1) << i), 1'b1, "R2 R11 data bit fixed");
    end
  endtask

  task automatic t_check_flips();
    int cpos [4] = '{1, 2, 4, 8};
    for (int k = 0; k < 4; k++) begin
      do_write(40 + k, 8'hC3, 1'b0);
      inject(40 + k, cpos[k]);
      do_read(40 + k, 8'hC3, 1'b1, "R3 check bit flip");
    end
  endtask

  task automatic t_no_writeback();
    do_read(22, 8'h5E, 1'b1, "R4 first read");
    do_read(22, 8'h5E, 1'b1, "R4 fault persists");
    do_write(22, 8'h5E, 1'b0);
    do_read(22, 8'h5E, 1'b0, "R4 rewrite clears");
  endtask

  task automatic t_addr_track();
    @(negedge clk);
    sleep_n = 1'b1; cs_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b0; addr = AW'(5);
    #1;
    chk(rdata == 8'hA5 && !err_flag, "R10 first addr", {rdata, err_flag}, 9'h14A);
    #1;
    addr = AW'(41);
    #1;
    chk(rdata == 8'hC3 && err_flag, "R10 addr change same cycle",
        {rdata, err_flag}, 9'h187);
  endtask

  task automatic t_reset_blocks();
    @(negedge clk);
    rst_n = 1'b0;
    do_write(5, 8'h77, 1'b0);
    inject(6, 3);
    @(negedge clk);
    rst_n = 1'b1;
    do_read(5, 8'hA5, 1'b0, "R12 write ignored in reset");
    do_read(6, 8'h3C, 1'b0, "R12 inject ignored in reset");
  endtask

  initial begin : watchdog
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_sleep();
    rst_n = 1'b1;
    idle();
    t_basic();
    t_write_oe_low();
    t_outputs_off();
    t_standby();
    t_sleep();
    t_data_flips();
    t_check_flips();
    t_no_writeback();
    t_addr_track();
    t_reset_blocks();
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule